// File: doc/BRIEF.md
# Cache Lock Status and Flash-Clear Controller

This block keeps the lock-related part of a cache control word. It has a register port for writing and reading that word. It stores a few plain configuration bits, and it holds two status flags. The cache sets these flags when a lock attempt fails or when a set is overlocked. Software clears them by writing 0, and writing 1 never sets them.

Software writes 1 to the flash-clear bit to start a sweep of the lock-bit array. The sweep visits one set per clock, from set 0 up to the last set. For each set it drives a clear enable and a set index. When the last set is done, the start bit returns to 0 on its own. The sweep does not look at the cache-enable bit. No write made while a sweep is running can start, stop or restart it.

Top module: `cache_lock_ctrl`

## Requirements
- R1: After reset, the whole control word reads 0 and the clear enable output is low.
- R2: Bits 0 to 4 of the control word are plain read/write fields. Bit 0 is cache enable, bit 1 is push-buffer disable, bit 2 is store-buffer disable, bit 3 is streaming disable and bit 4 is parity enable. Each write stores them, and they read back unchanged from the next cycle on.
- R3: Bit 5 is the unable-to-lock flag. It reads 1 in the cycle after a pulse on the unable-to-lock event input, and it stays 1 until software writes 0 to it.
- R4: Bit 6 is the lock-overflow flag. It reads 1 in the cycle after a pulse on the overflow event input, and it stays 1 until software writes 0 to it.
- R5: A write with 0 in a flag bit clears that flag. A write with 1 in a flag bit leaves the flag as it was.
- R6: If an event and a write of 0 reach the same flag in the same cycle, the flag reads 1 afterwards.
- R7: A write with bit 7 set while no sweep is running starts a sweep. From the next cycle, the clear enable is high for exactly NUM_SETS cycles. During those cycles the set index steps 0, 1, ... NUM_SETS-1. After that, the clear enable goes low.
- R8: Bit 7 reads 1 on every cycle in which the sweep is active, and it reads 0 once the sweep has finished.
- R9: A write made during a sweep, whether bit 7 is 0 or 1, does not change the sweep's index sequence or its length. The other fields of that write are still stored.
- R10: The sweep runs identically whether cache enable (bit 0) is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe for the control word |
| regWrData | input | 8 | Data to write to the control word |
| regRdData | output | 8 | Current control word |
| unableToLockEvt | input | 1 | One-cycle pulse from the cache: a lock attempt failed |
| lockOverflowEvt | input | 1 | One-cycle pulse from the cache: a set was overlocked |
| clrEn | output | 1 | Clear-enable to the lock-bit array |
| clrSet | output | SET_W | Index of the set being cleared |

## Verification
Two kinds of event can land in the same clock cycle. The first is a hardware flag set arriving together with a software write that clears that flag. The bench drives the event pulse and the clearing write on the same edge, then checks that the flag reads 1. The second is a register write arriving in the middle of a running sweep. The bench issues writes at chosen sweep positions, some with the start bit at 1 and some at 0. It compares each following cycle's set index with a counter it keeps itself. It also checks that the rest of the written word was stored.

// File: rtl/cache_lock_pkg.sv
package cache_lock_pkg;
  localparam int WORD_W   = 8;
  localparam int CFG_W    = 5;
  localparam int UTL_BIT  = 5;
  localparam int OVF_BIT  = 6;
  localparam int FCLR_BIT = 7;

  typedef struct packed {
    logic cfgWr;
    logic utlClr;
    logic ovfClr;
    logic sweepBusy;
  } ctrlStrobe_t;
endpackage

// File: rtl/lock_sweep_ctrl.sv
module lock_sweep_ctrl
  import cache_lock_pkg::*;
#(
  parameter int NUM_SETS = 64,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [WORD_W-1:0] regWrData,
  output ctrlStrobe_t       strobe,
  output logic              clrEn,
  output logic [SET_W-1:0]  clrSet
);
  localparam logic [SET_W-1:0] LAST_SET = SET_W'(NUM_SETS - 1);

  logic             busy;
  logic [SET_W-1:0] setIdx;
  logic             startReq;

  assign startReq = regWrEn && regWrData[FCLR_BIT] && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      setIdx <= '0;
    end else if (busy) begin
      if (setIdx == LAST_SET) begin
        busy   <= 1'b0;
        setIdx <= '0;
      end else begin
        setIdx <= setIdx + 1'b1;
      end
    end else if (startReq) begin
      busy   <= 1'b1;
      setIdx <= '0;
    end
  end

  always_comb begin
    strobe.cfgWr     = regWrEn;
    strobe.utlClr    = regWrEn && !regWrData[UTL_BIT];
    strobe.ovfClr    = regWrEn && !regWrData[OVF_BIT];
    strobe.sweepBusy = busy;
  end

  assign clrEn  = busy;
  assign clrSet = setIdx;
endmodule

// File: rtl/lock_reg_dp.sv
module lock_reg_dp
  import cache_lock_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [WORD_W-1:0] regWrData,
  input  logic              unableToLockEvt,
  input  logic              lockOverflowEvt,
  output logic [WORD_W-1:0] regRdData
);
  logic [CFG_W-1:0] cfgBits;
  logic             utlFlag;
  logic             ovfFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgBits <= '0;
      utlFlag <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      if (strobe.cfgWr) cfgBits <= regWrData[CFG_W-1:0];
      utlFlag <= unableToLockEvt || (utlFlag && !strobe.utlClr);
      ovfFlag <= lockOverflowEvt || (ovfFlag && !strobe.ovfClr);
    end
  end

  always_comb begin
    regRdData                = '0;
    regRdData[CFG_W-1:0]     = cfgBits;
    regRdData[UTL_BIT]       = utlFlag;
    regRdData[OVF_BIT]       = ovfFlag;
    regRdData[FCLR_BIT]      = strobe.sweepBusy;
  end
endmodule

// File: rtl/cache_lock_ctrl.sv
module cache_lock_ctrl
  import cache_lock_pkg::*;
#(
  parameter int NUM_SETS = 64,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  logic              unableToLockEvt,
  input  logic              lockOverflowEvt,
  output logic              clrEn,
  output logic [SET_W-1:0]  clrSet
);
  ctrlStrobe_t strobe;

  lock_sweep_ctrl #(.NUM_SETS(NUM_SETS)) ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .strobe    (strobe),
    .clrEn     (clrEn),
    .clrSet    (clrSet)
  );

  lock_reg_dp dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .regWrData       (regWrData),
    .unableToLockEvt (unableToLockEvt),
    .lockOverflowEvt (lockOverflowEvt),
    .regRdData       (regRdData)
  );
endmodule

// File: rtl/cache_lock_chk.sv
module cache_lock_chk
  import cache_lock_pkg::*;
#(
  parameter int NUM_SETS = 64,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [WORD_W-1:0] regWrData,
  input logic [WORD_W-1:0] regRdData,
  input logic              unableToLockEvt,
  input logic              lockOverflowEvt,
  input logic              clrEn,
  input logic [SET_W-1:0]  clrSet
);
  localparam logic [SET_W-1:0] LAST_SET = SET_W'(NUM_SETS - 1);

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> $stable(regRdData[CFG_W-1:0]));

  assert_utl_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    unableToLockEvt |=> regRdData[UTL_BIT]);

  assert_ovf_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    lockOverflowEvt |=> regRdData[OVF_BIT]);

  assert_utl_no_sw_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!regRdData[UTL_BIT] && !unableToLockEvt) |=> !regRdData[UTL_BIT]);

  assert_utl_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[UTL_BIT] && !(regWrEn && !regWrData[UTL_BIT])) |=> regRdData[UTL_BIT]);

  assert_sweep_first_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clrEn) |-> (clrSet == '0));

  assert_sweep_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (clrEn && clrSet != LAST_SET) |=> (clrEn && clrSet == SET_W'($past(clrSet) + 1'b1)));

  assert_sweep_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    (clrEn && clrSet == LAST_SET) |=> !clrEn);

  assert_busy_bit_R8: assert property (@(posedge clk) disable iff (!rstN)
    clrEn |-> regRdData[FCLR_BIT]);
endmodule

bind cache_lock_ctrl cache_lock_chk #(.NUM_SETS(NUM_SETS)) chk (
  .clk             (clk),
  .rstN            (rstN),
  .regWrEn         (regWrEn),
  .regWrData       (regWrData),
  .regRdData       (regRdData),
  .unableToLockEvt (unableToLockEvt),
  .lockOverflowEvt (lockOverflowEvt),
  .clrEn           (clrEn),
  .clrSet          (clrSet)
);

// File: tb/cache_lock_ctrl_test.sv
module cache_lock_ctrl_test;
  localparam int N = 8;
  localparam int SW = $clog2(N);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic unableToLockEvt = 1'b0;
  logic lockOverflowEvt = 1'b0;
  logic clrEn;
  logic [SW-1:0] clrSet;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cache_lock_ctrl #(.NUM_SETS(N)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .unableToLockEvt(unableToLockEvt),
    .lockOverflowEvt(lockOverflowEvt), .clrEn(clrEn), .clrSet(clrSet)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    regWrEn = 1'b1; regWrData = d;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic sweep(input logic [7:0] startWord, input int hitPos,
                       input logic [7:0] hitWord, input string tag);
    logic [4:0] expCfg = startWord[4:0];
    wr(startWord);
    for (int k = 0; k < N; k++) begin
      check(clrEn === 1'b1 && clrSet == SW'(k), tag, {clrEn, clrSet}, {1'b1, SW'(k)});
      check(regRdData[7] === 1'b1, "R8 busy bit", regRdData[7], 1);
      if (k == hitPos) begin
        regWrEn = 1'b1; regWrData = hitWord; expCfg = hitWord[4:0];
      end
      @(negedge clk);
      regWrEn = 1'b0;
    end
    check(clrEn === 1'b0, tag, clrEn, 0);
    check(regRdData[7] === 1'b0, "R8 bit cleared", regRdData[7], 0);
    check(regRdData[4:0] == expCfg, "R9 fields stored", regRdData[4:0], expCfg);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(regRdData == 8'h00, "R1 reset word", regRdData, 0);
    check(clrEn === 1'b0, "R1 reset clrEn", clrEn, 0);

    for (int v = 0; v < 32; v++) begin
      wr(8'(v));
      check(regRdData == 8'(v), "R2 config readback", regRdData, v);
      check(clrEn === 1'b0, "R2 no sweep", clrEn, 0);
    end
    wr(8'h00);

    unableToLockEvt = 1'b1; @(negedge clk); unableToLockEvt = 1'b0;
    check(regRdData[5] === 1'b1, "R3 utl set", regRdData[5], 1);
    repeat (3) @(negedge clk);
    check(regRdData[5] === 1'b1, "R3 utl sticky", regRdData[5], 1);
    check(regRdData[6] === 1'b0, "R4 ovf untouched", regRdData[6], 0);
    lockOverflowEvt = 1'b1; @(negedge clk); lockOverflowEvt = 1'b0;
    check(regRdData[6] === 1'b1, "R4 ovf set", regRdData[6], 1);
    wr(8'h60);
    check(regRdData[6:5] == 2'b11, "R5 write 1 keeps flags", regRdData[6:5], 3);
    wr(8'h40);
    check(regRdData[6:5] == 2'b10, "R5 clear utl only", regRdData[6:5], 2);
    wr(8'h00);
    check(regRdData[6:5] == 2'b00, "R5 clear ovf", regRdData[6:5], 0);
    wr(8'h60);
    check(regRdData[6:5] == 2'b00, "R5 write 1 no set", regRdData[6:5], 0);

    unableToLockEvt = 1'b1; lockOverflowEvt = 1'b1; wr(8'h00);
    unableToLockEvt = 1'b0; lockOverflowEvt = 1'b0;
    check(regRdData[6:5] == 2'b11, "R6 event wins", regRdData[6:5], 3);
    wr(8'h00);

    sweep(8'h80, -1, 8'h00, "R10 sweep enable=0");
    sweep(8'h81, -1, 8'h00, "R7 sweep enable=1");
    for (int p = 0; p < N; p++) begin
      sweep(8'h83, p, 8'h9C, "R9 rewrite start");
      sweep(8'h80, p, 8'h05, "R9 write zero");
    end
    wr(8'h00);
    check(clrEn === 1'b0, "R7 idle after", clrEn, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule